// File: doc/BRIEF.md
# UART Interrupt Enable and Sleep Gating

This block sits beside the register file of a 550-family serial channel. It combines the 8-bit interrupt enable register, the operating mode bits and a global interrupt enable into one active-low interrupt request. The block also reports a 3-bit source code for the highest-priority pending cause. The meaning of several enable bits depends on the mode: enhanced mode, 750-compatible mode, or 9-bit framing mode.

The block holds four programmable character entries. In 9-bit framing mode it compares each received data byte against all four entries, and a match raises a sticky special-character event. A received character with its ninth (address) bit set raises a sticky address event. Both sticky events clear when the identification register is read. In enhanced mode without 9-bit framing, two of the entries serve as XOFF characters, and a match gives a one-cycle detect pulse to the flow-control logic. The block also produces the channel's sleep request. The request is withheld while any enabled interrupt is pending or the receiver is busy, so the clock cannot stop in the middle of an event.

Top module: `uart_irq_gate`

## Requirements
- R1: `irq_n_o` goes low one clock after an enabled request is present with `glb_en_i` high. It is high whenever `glb_en_i` was low on the previous clock, and it is high after reset.
- R2: Enable bit 0 gates the receive-data event, bit 1 gates the transmitter-empty event and bit 3 gates the modem-status event.
- R3: Enable bit 2 gates the line-status event. In 9-bit mode it also gates a sticky address event. That event is set by a received character (`rx_valid_i` high) whose bit 8 is 1.
- R4: `irq_id_o` gives the highest pending source, and 0 when nothing is pending. From highest to lowest priority the codes are: address 1, line status 2, receive data 3, transmitter empty 4, special character 5, modem status 6, RTS/CTS change 7.
- R5: In 9-bit mode, enable bit 5 gates a sticky special-character event. The event is set when received bits [7:0] equal any of the four entries.
- R6: A one-cycle `iir_rd_i` pulse clears both sticky events. A new event in the same cycle as the pulse wins over the clear.
- R7: Enable bits 6 and 7 gate the RTS-change and CTS-change events only in enhanced mode. Outside enhanced mode both events are always enabled.
- R8: In enhanced mode without 9-bit framing and with enable bit 5 set, `xoff_det_o` pulses for one clock, one clock after a received byte matches entry 2 (when `xon_flow_i` is set) or entry 3 (when `xoff2_en_i` is set).
- R9: The sleep request comes from enable bit 4. In 750 mode with enhanced and 9-bit framing both off, bit 5 also gives the sleep request.
- R10: `sleep_o` is registered, and it is low whenever an enabled interrupt is pending or `rx_busy_i` is high.
- R11: Outside 9-bit mode, received characters never raise the address event or the special-character event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_i | input | 8 | Interrupt enable register |
| enh_i | input | 1 | Enhanced mode |
| mode750_i | input | 1 | 750-compatible mode |
| ninebit_i | input | 1 | 9-bit framing mode |
| glb_en_i | input | 1 | Global interrupt enable |
| ev_rxd_i | input | 1 | Receive data ready |
| ev_txe_i | input | 1 | Transmitter empty |
| ev_lsr_i | input | 1 | Line status event |
| ev_msr_i | input | 1 | Modem status event |
| ev_rts_i | input | 1 | RTS change |
| ev_cts_i | input | 1 | CTS change |
| rx_valid_i | input | 1 | Received character strobe |
| rx_char_i | input | 9 | Received character, bit 8 is the address bit |
| spc_we_i | input | 1 | Special character entry write enable |
| spc_sel_i | input | 2 | Entry select |
| spc_wdata_i | input | 8 | Entry write data |
| xon_flow_i | input | 1 | In-band flow control selected |
| xoff2_en_i | input | 1 | Second XOFF character enabled |
| iir_rd_i | input | 1 | Identification register read strobe |
| rx_busy_i | input | 1 | Receiver mid-character |
| irq_n_o | output | 1 | Active-low interrupt |
| irq_id_o | output | 3 | Highest pending source code |
| sleep_o | output | 1 | Sleep request |
| xoff_det_o | output | 1 | XOFF character detected |

## Verification
The assertions assume that `rx_valid_i` and `iir_rd_i` are single-cycle strobes and that the mode bits and enables change only between events. They do not model a mode change while a sticky event is pending. The stimulus holds every level input steady for at least two clocks before it samples. Strobes are driven for one clock each, on the falling edge, and the mode bits are never changed while a sticky flag is set, except where a read clears the flag first.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int IER_W   = 8;
  localparam int NUM_SRC = 7;
  localparam int ID_W    = 3;

  typedef enum logic [ID_W-1:0] {
    ID_NONE = 3'd0,
    ID_ADDR = 3'd1,
    ID_LSR  = 3'd2,
    ID_RXD  = 3'd3,
    ID_TXE  = 3'd4,
    ID_SPC  = 3'd5,
    ID_MSR  = 3'd6,
    ID_FLOW = 3'd7
  } irq_id_e;

  // enable register bit positions
  localparam int EN_RXD  = 0;
  localparam int EN_TXE  = 1;
  localparam int EN_LSR  = 2;
  localparam int EN_MSR  = 3;
  localparam int EN_SLP  = 4;
  localparam int EN_SPC  = 5;
  localparam int EN_RTS  = 6;
  localparam int EN_CTS  = 7;
endpackage

// File: rtl/uirq_spc_match.sv
module uirq_spc_match #(
  parameter int NUM    = 4,
  parameter int CW     = 8,
  parameter int SEL_W  = $clog2(NUM)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [CW-1:0]    wdata_i,
  input  logic [CW-1:0]    char_i,
  output logic [NUM-1:0]   hit_o,
  output logic             any_o
);

  for (genvar g = 0; g < NUM; g++) begin : g_entry
    logic [CW-1:0] val_q;
    logic [CW-1:0] val_d;
    logic          wr_en;

    assign wr_en = we_i && (sel_i == SEL_W'(g));

    always_comb begin
      val_d = val_q;
      if (wr_en) val_d = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= '0;
      else        val_q <= val_d;
    end

    assign hit_o[g] = (val_q == char_i);
  end

  assign any_o = |hit_o;

endmodule

// File: rtl/uirq_prio.sv
module uirq_prio #(
  parameter int N = 7,
  parameter int W = 3
) (
  input  logic [N-1:0] req_i,   // bit 0 is the highest priority
  output logic [W-1:0] id_o     // 0 = nothing pending, else index+1
);

  always_comb begin
    id_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) id_o = W'(i + 1);
    end
  end

endmodule

// File: rtl/uart_irq_gate.sv
module uart_irq_gate
  import uirq_pkg::*;
#(
  parameter int CHAR_W    = 8,
  parameter int NUM_SPC   = 4,
  parameter int XOFF1_IDX = 2,
  parameter int XOFF2_IDX = 3,
  localparam int SEL_W    = $clog2(NUM_SPC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IER_W-1:0]  ier_i,
  input  logic              enh_i,
  input  logic              mode750_i,
  input  logic              ninebit_i,
  input  logic              glb_en_i,
  input  logic              ev_rxd_i,
  input  logic              ev_txe_i,
  input  logic              ev_lsr_i,
  input  logic              ev_msr_i,
  input  logic              ev_rts_i,
  input  logic              ev_cts_i,
  input  logic              rx_valid_i,
  input  logic [CHAR_W:0]   rx_char_i,
  input  logic              spc_we_i,
  input  logic [SEL_W-1:0]  spc_sel_i,
  input  logic [CHAR_W-1:0] spc_wdata_i,
  input  logic              xon_flow_i,
  input  logic              xoff2_en_i,
  input  logic              iir_rd_i,
  input  logic              rx_busy_i,
  output logic              irq_n_o,
  output logic [ID_W-1:0]   irq_id_o,
  output logic              sleep_o,
  output logic              xoff_det_o
);

  // ---------------- special character store and compare
  logic [NUM_SPC-1:0] hit;
  logic               hit_any;

  uirq_spc_match #(.NUM(NUM_SPC), .CW(CHAR_W)) u_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (spc_we_i),
    .sel_i   (spc_sel_i),
    .wdata_i (spc_wdata_i),
    .char_i  (rx_char_i[CHAR_W-1:0]),
    .hit_o   (hit),
    .any_o   (hit_any)
  );

  // ---------------- sticky 9-bit events
  logic addr_pend_q, addr_pend_d;
  logic spc_pend_q,  spc_pend_d;
  logic addr_set, spc_set;

  assign addr_set = rx_valid_i && ninebit_i && rx_char_i[CHAR_W];
  assign spc_set  = rx_valid_i && ninebit_i && hit_any;

  always_comb begin
    addr_pend_d = addr_pend_q;
    spc_pend_d  = spc_pend_q;
    if (iir_rd_i) begin
      addr_pend_d = 1'b0;
      spc_pend_d  = 1'b0;
    end
    if (addr_set) addr_pend_d = 1'b1;
    if (spc_set)  spc_pend_d  = 1'b1;
  end

  // ---------------- mode-dependent enables
  logic en_addr, en_lsr, en_rxd, en_txe, en_spc, en_msr, en_rts, en_cts;

  always_comb begin
    en_rxd  = ier_i[EN_RXD];
    en_txe  = ier_i[EN_TXE];
    en_lsr  = ier_i[EN_LSR];
    en_msr  = ier_i[EN_MSR];
    en_addr = ninebit_i && ier_i[EN_LSR];
    en_spc  = ninebit_i && ier_i[EN_SPC];
    en_rts  = enh_i ? ier_i[EN_RTS] : 1'b1;
    en_cts  = enh_i ? ier_i[EN_CTS] : 1'b1;
  end

  // request vector, index 0 highest priority
  logic [NUM_SRC-1:0] req;

  always_comb begin
    req = '0;
    req[int'(ID_ADDR) - 1] = en_addr && addr_pend_q;
    req[int'(ID_LSR)  - 1] = en_lsr  && ev_lsr_i;
    req[int'(ID_RXD)  - 1] = en_rxd  && ev_rxd_i;
    req[int'(ID_TXE)  - 1] = en_txe  && ev_txe_i;
    req[int'(ID_SPC)  - 1] = en_spc  && spc_pend_q;
    req[int'(ID_MSR)  - 1] = en_msr  && ev_msr_i;
    req[int'(ID_FLOW) - 1] = (en_rts && ev_rts_i) || (en_cts && ev_cts_i);
    if (!glb_en_i) req = '0;
  end

  logic [ID_W-1:0] id_d;

  uirq_prio #(.N(NUM_SRC), .W(ID_W)) u_prio (
    .req_i (req),
    .id_o  (id_d)
  );

  // ---------------- sleep request
  logic sleep_req, sleep_d;

  always_comb begin
    sleep_req = ier_i[EN_SLP] ||
                (mode750_i && !enh_i && !ninebit_i && ier_i[EN_SPC]);
    sleep_d   = sleep_req && !(|req) && !rx_busy_i;
  end

  // ---------------- XOFF detection for flow control
  logic xoff_d;

  always_comb begin
    xoff_d = rx_valid_i && enh_i && !ninebit_i && ier_i[EN_SPC] &&
             ((xon_flow_i && hit[XOFF1_IDX]) || (xoff2_en_i && hit[XOFF2_IDX]));
  end

  // ---------------- registers
  logic            irq_n_q;
  logic [ID_W-1:0] id_q;
  logic            sleep_q;
  logic            xoff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_pend_q <= 1'b0;
      spc_pend_q  <= 1'b0;
      irq_n_q     <= 1'b1;
      id_q        <= '0;
      sleep_q     <= 1'b0;
      xoff_q      <= 1'b0;
    end else begin
      addr_pend_q <= addr_pend_d;
      spc_pend_q  <= spc_pend_d;
      irq_n_q     <= ~(|req);
      id_q        <= id_d;
      sleep_q     <= sleep_d;
      xoff_q      <= xoff_d;
    end
  end

  assign irq_n_o    = irq_n_q;
  assign irq_id_o   = id_q;
  assign sleep_o    = sleep_q;
  assign xoff_det_o = xoff_q;

endmodule

// File: rtl/uirq_chk.sv
module uirq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ier_i,
  input logic       enh_i,
  input logic       mode750_i,
  input logic       ninebit_i,
  input logic       glb_en_i,
  input logic       rx_valid_i,
  input logic       rx_busy_i,
  input logic       irq_n_o,
  input logic [2:0] irq_id_o,
  input logic       sleep_o,
  input logic       xoff_det_o
);

  // R4: no source code while the line is idle
  p_idle_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n_o |-> (irq_id_o == 3'd0));

  // R4: an asserted line always reports a source
  p_active_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n_o |-> (irq_id_o != 3'd0));

  // R1: a cleared global enable keeps the line high on the next clock
  p_glb_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en_i |=> irq_n_o);

  // R10: a busy receiver holds off sleep
  p_busy_no_sleep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_busy_i |=> !sleep_o);

  // R10: sleep and a pending interrupt never coexist
  p_sleep_vs_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_o |-> irq_n_o);

  // R9: sleep only follows a sleep request
  p_sleep_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_o |-> $past(ier_i[4] || (mode750_i && !enh_i && !ninebit_i && ier_i[5])));

  // R8: XOFF detect only after a strobe in enhanced non-9-bit mode
  p_xoff_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xoff_det_o |-> $past(rx_valid_i && enh_i && !ninebit_i && ier_i[5]));

endmodule

bind uart_irq_gate uirq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ier_i      (ier_i),
  .enh_i      (enh_i),
  .mode750_i  (mode750_i),
  .ninebit_i  (ninebit_i),
  .glb_en_i   (glb_en_i),
  .rx_valid_i (rx_valid_i),
  .rx_busy_i  (rx_busy_i),
  .irq_n_o    (irq_n_o),
  .irq_id_o   (irq_id_o),
  .sleep_o    (sleep_o),
  .xoff_det_o (xoff_det_o)
);

// File: tb/uart_irq_gate_tb.sv
module uart_irq_gate_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk, rst_n;
  logic [7:0] ier;
  logic       enh, m750, nine, glb;
  logic       ev_rxd, ev_txe, ev_lsr, ev_msr, ev_rts, ev_cts;
  logic       rx_valid;
  logic [8:0] rx_char;
  logic       spc_we;
  logic [1:0] spc_sel;
  logic [7:0] spc_wdata;
  logic       xon_flow, xoff2_en, iir_rd, rx_busy;
  logic       irq_n;
  logic [2:0] irq_id;
  logic       sleep, xoff_det;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  uart_irq_gate dut_i (
    .clk(clk), .rst_n(rst_n), .ier_i(ier), .enh_i(enh), .mode750_i(m750),
    .ninebit_i(nine), .glb_en_i(glb), .ev_rxd_i(ev_rxd), .ev_txe_i(ev_txe),
    .ev_lsr_i(ev_lsr), .ev_msr_i(ev_msr), .ev_rts_i(ev_rts), .ev_cts_i(ev_cts),
    .rx_valid_i(rx_valid), .rx_char_i(rx_char), .spc_we_i(spc_we),
    .spc_sel_i(spc_sel), .spc_wdata_i(spc_wdata), .xon_flow_i(xon_flow),
    .xoff2_en_i(xoff2_en), .iir_rd_i(iir_rd), .rx_busy_i(rx_busy),
    .irq_n_o(irq_n), .irq_id_o(irq_id), .sleep_o(sleep), .xoff_det_o(xoff_det)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Vector: {req4, ier8, {enh,m750,nine,glb}, {rxd,txe,lsr,msr,rts,cts}, busy,
  //          exp_irq_n, exp_id3, exp_sleep}
  localparam int NV = 17;
  localparam logic [27:0] VEC [NV] = '{
    {4'd2,  8'h01, 4'b0001, 6'b100000, 1'b0, 1'b0, 3'd3, 1'b0}, // R2 rx data
    {4'd2,  8'h00, 4'b0001, 6'b100000, 1'b0, 1'b1, 3'd0, 1'b0}, // R2 disabled
    {4'd4,  8'h0F, 4'b0001, 6'b111100, 1'b0, 1'b0, 3'd2, 1'b0}, // R4 lsr wins
    {4'd4,  8'h0A, 4'b0001, 6'b111100, 1'b0, 1'b0, 3'd4, 1'b0}, // R4 txe next
    {4'd2,  8'h08, 4'b0001, 6'b000100, 1'b0, 1'b0, 3'd6, 1'b0}, // R2 modem
    {4'd1,  8'h0F, 4'b0000, 6'b111111, 1'b0, 1'b1, 3'd0, 1'b0}, // R1 global off
    {4'd7,  8'h00, 4'b0001, 6'b000010, 1'b0, 1'b0, 3'd7, 1'b0}, // R7 rts non-enh
    {4'd7,  8'h00, 4'b1001, 6'b000011, 1'b0, 1'b1, 3'd0, 1'b0}, // R7 enh masked
    {4'd7,  8'h80, 4'b1001, 6'b000001, 1'b0, 1'b0, 3'd7, 1'b0}, // R7 cts enabled
    {4'd9,  8'h10, 4'b0001, 6'b000000, 1'b0, 1'b1, 3'd0, 1'b1}, // R9 sleep
    {4'd10, 8'h10, 4'b0001, 6'b000000, 1'b1, 1'b1, 3'd0, 1'b0}, // R10 busy
    {4'd10, 8'h11, 4'b0001, 6'b100000, 1'b0, 1'b0, 3'd3, 1'b0}, // R10 pending
    {4'd9,  8'h20, 4'b0101, 6'b000000, 1'b0, 1'b1, 3'd0, 1'b1}, // R9 750 alt
    {4'd9,  8'h20, 4'b1101, 6'b000000, 1'b0, 1'b1, 3'd0, 1'b0}, // R9 enh blocks
    {4'd9,  8'h20, 4'b0111, 6'b000000, 1'b0, 1'b1, 3'd0, 1'b0}, // R9 9-bit blocks
    {4'd3,  8'h04, 4'b0011, 6'b001000, 1'b0, 1'b0, 3'd2, 1'b0}, // R3 lsr 9-bit
    {4'd10, 8'h10, 4'b0000, 6'b100000, 1'b0, 1'b1, 3'd0, 1'b1}  // R10 masked ok
  };

  task automatic check(string rq, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_rx(input logic [8:0] ch);
    @(negedge clk);
    rx_valid = 1'b1; rx_char = ch;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk);
    iir_rd = 1'b1;
    @(negedge clk);
    iir_rd = 1'b0;
  endtask

  task automatic write_spc(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    spc_we = 1'b1; spc_sel = s; spc_wdata = d;
    @(negedge clk);
    spc_we = 1'b0;
  endtask

  task automatic set_mode(input logic [3:0] m);
    {enh, m750, nine, glb} = m;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    ier = '0; set_mode(4'b0000);
    {ev_rxd, ev_txe, ev_lsr, ev_msr, ev_rts, ev_cts} = '0;
    rx_valid = 0; rx_char = '0; spc_we = 0; spc_sel = '0; spc_wdata = '0;
    xon_flow = 0; xoff2_en = 0; iir_rd = 0; rx_busy = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "reset irq_n", int'(irq_n), 1);
    check("R4", "reset id", int'(irq_id), 0);
    check("R10", "reset sleep", int'(sleep), 0);
    check("R8", "reset xoff", int'(xoff_det), 0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      logic [3:0] rq; logic [3:0] md; logic [5:0] ev;
      logic b, en, es; logic [2:0] eid; logic [7:0] ie;
      {rq, ie, md, ev, b, en, eid, es} = VEC[k];
      @(negedge clk);
      ier = ie; set_mode(md); rx_busy = b;
      {ev_rxd, ev_txe, ev_lsr, ev_msr, ev_rts, ev_cts} = ev;
      settle();
      check($sformatf("R%0d", rq), $sformatf("vec %0d irq_n", k), int'(irq_n), int'(en));
      check($sformatf("R%0d", rq), $sformatf("vec %0d id", k), int'(irq_id), int'(eid));
      check($sformatf("R%0d", rq), $sformatf("vec %0d sleep", k), int'(sleep), int'(es));
    end

    {ev_rxd, ev_txe, ev_lsr, ev_msr, ev_rts, ev_cts} = '0;
    rx_busy = 0;

    write_spc(2'd0, 8'h11);
    write_spc(2'd1, 8'h22);
    write_spc(2'd2, 8'h33);
    write_spc(2'd3, 8'h44);

    // R5: 9-bit special character match
    ier = 8'h20; set_mode(4'b0011);
    pulse_rx(9'h055);
    settle();
    check("R5", "no match irq_n", int'(irq_n), 1);
    pulse_rx(9'h022);
    settle();
    check("R5", "match irq_n", int'(irq_n), 0);
    check("R5", "match id", int'(irq_id), 5);
    settle();
    check("R5", "sticky id", int'(irq_id), 5);
    // R10: sleep requested but pending blocks it
    ier = 8'h30;
    settle();
    check("R10", "sleep held by pending", int'(sleep), 0);
    ier = 8'h20;
    // R6: read clears
    pulse_rd();
    settle();
    check("R6", "cleared irq_n", int'(irq_n), 1);

    // R3 / R4: address bit ranks above special char
    ier = 8'h24;
    pulse_rx(9'h144);
    settle();
    check("R3", "addr id", int'(irq_id), 1);
    check("R4", "addr over spc irq_n", int'(irq_n), 0);
    ier = 8'h20;
    settle();
    check("R4", "spc after addr masked", int'(irq_id), 5);
    pulse_rd();
    settle();
    check("R6", "both cleared", int'(irq_n), 1);

    // R6: set wins over clear in the same cycle
    @(negedge clk);
    rx_valid = 1'b1; rx_char = 9'h011; iir_rd = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; iir_rd = 1'b0;
    settle();
    check("R6", "set wins id", int'(irq_id), 5);
    pulse_rd();
    settle();
    check("R6", "cleared again", int'(irq_n), 1);

    // R11: outside 9-bit mode no address or special events
    ier = 8'h24; set_mode(4'b1001);
    pulse_rx(9'h133);
    settle();
    check("R11", "no irq outside 9-bit", int'(irq_n), 1);
    ier = 8'h24; set_mode(4'b0011);
    settle();
    check("R11", "nothing latched outside 9-bit", int'(irq_n), 1);

    // R8: XOFF detection
    ier = 8'h20; set_mode(4'b1001); xon_flow = 1; xoff2_en = 0;
    @(negedge clk);
    rx_valid = 1'b1; rx_char = 9'h033;
    @(negedge clk);
    rx_valid = 1'b0;
    check("R8", "xoff1 pulse", int'(xoff_det), 1);
    @(negedge clk);
    check("R8", "xoff1 one cycle", int'(xoff_det), 0);
    @(negedge clk);
    rx_valid = 1'b1; rx_char = 9'h044;
    @(negedge clk);
    rx_valid = 1'b0;
    check("R8", "xoff2 disabled", int'(xoff_det), 0);
    xoff2_en = 1;
    @(negedge clk);
    rx_valid = 1'b1; rx_char = 9'h044;
    @(negedge clk);
    rx_valid = 1'b0;
    check("R8", "xoff2 pulse", int'(xoff_det), 1);
    set_mode(4'b1011);
    @(negedge clk);
    rx_valid = 1'b1; rx_char = 9'h033;
    @(negedge clk);
    rx_valid = 1'b0;
    check("R8", "no xoff in 9-bit", int'(xoff_det), 0);
    check("R8", "no irq from xoff in 9-bit", int'(irq_n), 1);
    settle();
    check("R5", "9-bit match pending", int'(irq_id), 5);
    pulse_rd();
    settle();

    finish_run();
  end

endmodule